// File: doc/BRIEF.md
# Word-Serial Multiply-Accumulate Row

This block computes one row of a multi-precision product. A long operand of up to `MAX_WORDS` 32-bit words sits in one RAM, and a running partial result of the same length sits in a second, dual-port RAM. When started, the block latches a single 32-bit scalar and a word count. It then reads both RAMs at word addresses 0, 1, 2, ... in that order, one address per cycle. For each address it forms the 64-bit product of the operand word and the scalar, adds the accumulator word and the carry left by the previous word, and writes the low 32 bits back to the accumulator at the same address.

The upper 32 bits of each per-word sum are held in a register for exactly one cycle and are added into the next word's sum. The chain between words is therefore a single short loop, and no full-width carry-propagate add is needed. When the last word has been written, the remaining upper word is presented as a separate carry-out, together with a one-cycle done pulse. A surrounding sequencer issues one row per scalar word and handles any reduction. The word count covers 160-, 256-, 512- and 1024-bit operands, plus one spare top word.

Top module: `mac_row`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `acc_we` are all 0.
- R2: A `start` seen while `busy` is 0 latches `scalar` and `nwords`. In the next cycle `busy` is 1, `rd_en` is 1 and `rd_addr` is 0.
- R3: A row of n words reads addresses 0 to n-1 in ascending order, on n consecutive cycles.
- R4: Let c be 0 for word 0 and, for each later word, the upper 32 bits of the previous word's sum. Word j's sum is acc[j] + op[j]*scalar + c. This sum always fits in 64 bits, and its low 32 bits are written to accumulator address j.
- R5: Each write to address j comes exactly 3 cycles after the cycle in which address j was read. Writes arrive in ascending address order.
- R6: `done` is a single-cycle pulse. It falls in the same cycle as the write of word n-1, which is n+3 cycles after the cycle in which `start` was accepted. From that cycle on, `carry_out` holds the upper 32 bits of the last sum, and it keeps that value until the next `done`.
- R7: `start` is ignored while `busy` is 1, including in the `done` cycle. It changes neither the row in progress nor the state after it.
- R8: Accumulator words at addresses n and above are never written. Every count from 1 to `MAX_WORDS` is supported (5, 8, 16, 32 and 33 words among them).
- R9: `busy` stays 1 from the cycle after `start` through the `done` cycle, and is 0 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a row (taken only when idle) |
| scalar | input | 32 | Scalar word multiplying the long operand |
| nwords | input | $clog2(MAX_WORDS+1) | Number of words in the row, 1..MAX_WORDS |
| busy | output | 1 | Row in progress |
| done | output | 1 | One-cycle pulse at the end of the row |
| carry_out | output | 32 | Final carry word of the last row |
| rd_en | output | 1 | Read strobe for both RAMs |
| rd_addr | output | $clog2(MAX_WORDS) | Word address read from both RAMs |
| op_rdata | input | 32 | Operand word, valid one cycle after the read |
| acc_rdata | input | 32 | Accumulator word, valid one cycle after the read |
| acc_we | output | 1 | Accumulator write enable |
| acc_waddr | output | $clog2(MAX_WORDS) | Accumulator write address |
| acc_wdata | output | 32 | Accumulator write data |

## Verification
The write-back of the final word and the done pulse with its carry-out word land in the same cycle. In that cycle the bench checks the write enable, the write address n-1, and the carry value, all at once. Rows with all-ones operand, accumulator and scalar drive the carry chain to its upper bound, so a carry lost in that shared cycle shows up in both `carry_out` and the stored words. A `start` raised during that same done cycle must be ignored, and the bench confirms this by seeing `busy` low in the following cycle.

// File: rtl/mac_row_pkg.sv
package mac_row_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [2*WORD_W-1:0] dword_t;

  // Full product of two words.
  function automatic dword_t word_mul(word_t a, word_t b);
    return dword_t'(a) * dword_t'(b);
  endfunction

  // Accumulate one word: stored word + product + chained upper word.
  // Bounded by (2^32-1) + (2^32-1)^2 + (2^32-1) = 2^64-1.
  function automatic dword_t word_mac(word_t t, dword_t p, word_t c);
    return dword_t'(t) + p + dword_t'(c);
  endfunction
endpackage

// File: rtl/row_issue.sv
module row_issue #(
  parameter int MAX_WORDS = 33,
  localparam int AW = $clog2(MAX_WORDS),
  localparam int CW = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [CW-1:0] len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_last
);
  logic          active;
  logic [AW-1:0] idx;
  logic [AW-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
    end else if (launch) begin
      active   <= 1'b1;
      idx      <= '0;
      last_idx <= AW'(len - CW'(1));
    end else if (active) begin
      if (idx == last_idx) active <= 1'b0;
      else                 idx    <= idx + AW'(1);
    end
  end

  assign rd_en   = active;
  assign rd_addr = idx;
  assign rd_last = active && (idx == last_idx);
endmodule

// File: rtl/row_mul_stage.sv
module row_mul_stage
  import mac_row_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [AW-1:0] in_addr,
  input  word_t         a_word,
  input  word_t         t_word,
  input  word_t         y_word,
  output logic          out_valid,
  output logic          out_last,
  output logic [AW-1:0] out_addr,
  output dword_t        prod,
  output word_t         t_dly
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_last  <= in_valid && in_last;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_addr <= in_addr;
      prod     <= word_mul(a_word, y_word);
      t_dly    <= t_word;
    end
  end
endmodule

// File: rtl/row_acc_stage.sv
module row_acc_stage
  import mac_row_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [AW-1:0] in_addr,
  input  dword_t        prod,
  input  word_t         t_dly,
  output logic          we,
  output logic [AW-1:0] waddr,
  output word_t         wdata,
  output logic          done,
  output word_t         carry_out,
  output word_t         chain_carry
);
  dword_t sum;
  word_t  carry_q;

  assign sum         = word_mac(t_dly, prod, carry_q);
  assign chain_carry = carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we        <= 1'b0;
      done      <= 1'b0;
      carry_q   <= '0;
      carry_out <= '0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      we   <= in_valid;
      done <= in_valid && in_last;
      if (clear) begin
        carry_q <= '0;
      end else if (in_valid) begin
        carry_q <= sum[2*WORD_W-1:WORD_W];
      end
      if (in_valid) begin
        waddr <= in_addr;
        wdata <= sum[WORD_W-1:0];
        if (in_last) carry_out <= sum[2*WORD_W-1:WORD_W];
      end
    end
  end
endmodule

// File: rtl/mac_row.sv
module mac_row
  import mac_row_pkg::*;
#(
  parameter int MAX_WORDS = 33,
  localparam int AW = $clog2(MAX_WORDS),
  localparam int CW = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   scalar,
  input  logic [CW-1:0] nwords,
  output logic          busy,
  output logic          done,
  output logic [31:0]   carry_out,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   op_rdata,
  input  logic [31:0]   acc_rdata,
  output logic          acc_we,
  output logic [AW-1:0] acc_waddr,
  output logic [31:0]   acc_wdata
);
  // Named internal events for the checker.
  logic          start_ok;
  logic          rd_last;
  logic          v0, v0_last;
  logic [AW-1:0] v0_addr;
  logic          v1, v1_last;
  logic [AW-1:0] v1_addr;
  dword_t        prod;
  word_t         t_dly;
  word_t         y_q;
  word_t         chain_carry;

  assign start_ok = start && !busy;
  assign busy     = rd_en || v0 || v1 || acc_we;

  always_ff @(posedge clk) begin
    if (!rst_n)        y_q <= '0;
    else if (start_ok) y_q <= scalar;
  end

  row_issue #(.MAX_WORDS(MAX_WORDS)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (start_ok),
    .len     (nwords),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_last (rd_last)
  );

  // Tag alignment with the one-cycle RAM read latency.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0      <= 1'b0;
      v0_last <= 1'b0;
      v0_addr <= '0;
    end else begin
      v0      <= rd_en;
      v0_last <= rd_last;
      v0_addr <= rd_addr;
    end
  end

  row_mul_stage #(.AW(AW)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (v0),
    .in_last   (v0_last),
    .in_addr   (v0_addr),
    .a_word    (op_rdata),
    .t_word    (acc_rdata),
    .y_word    (y_q),
    .out_valid (v1),
    .out_last  (v1_last),
    .out_addr  (v1_addr),
    .prod      (prod),
    .t_dly     (t_dly)
  );

  row_acc_stage #(.AW(AW)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_ok),
    .in_valid    (v1),
    .in_last     (v1_last),
    .in_addr     (v1_addr),
    .prod        (prod),
    .t_dly       (t_dly),
    .we          (acc_we),
    .waddr       (acc_waddr),
    .wdata       (acc_wdata),
    .done        (done),
    .carry_out   (carry_out),
    .chain_carry (chain_carry)
  );
endmodule

// File: rtl/mac_row_chk.sv
module mac_row_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          acc_we,
  input logic [AW-1:0] acc_waddr,
  input logic          start_ok,
  input logic [31:0]   chain_carry
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!acc_we && !rd_en && !done));

  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && rd_en && rd_addr == '0));

  a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(1)));

  a_r4_chain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (chain_carry == 32'd0));

  a_r5_write_lag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> ($past(rd_en, 3) && acc_waddr == $past(rd_addr, 3)));

  a_r6_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> acc_we);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind mac_row mac_row_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .acc_we      (acc_we),
  .acc_waddr   (acc_waddr),
  .start_ok    (start_ok),
  .chain_carry (chain_carry)
);

// File: tb/sim_mac_row.sv
module sim_mac_row;
  localparam int MAXW = 33;
  localparam int AW   = $clog2(MAXW);
  localparam int CW   = $clog2(MAXW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   scalar = '0;
  logic [CW-1:0] nwords = '0;
  logic          busy, done, rd_en, acc_we;
  logic [31:0]   carry_out, acc_wdata;
  logic [AW-1:0] rd_addr, acc_waddr;
  logic [31:0]   op_q, acc_q;

  logic [31:0]   op_mem  [MAXW];
  logic [31:0]   acc_mem [MAXW];
  logic [31:0]   exp_mem [MAXW];
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;

  int checks = 0, fails = 0, cyc = 0, wexp = 0, order_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mac_row #(.MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar), .nwords(nwords),
    .busy(busy), .done(done), .carry_out(carry_out),
    .rd_en(rd_en), .rd_addr(rd_addr), .op_rdata(op_q), .acc_rdata(acc_q),
    .acc_we(acc_we), .acc_waddr(acc_waddr), .acc_wdata(acc_wdata)
  );

  // RAM models: registered read, write on the clock edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      op_q  <= op_mem[rd_addr];
      acc_q <= acc_mem[rd_addr];
    end
    if (acc_we) acc_mem[acc_waddr] <= acc_wdata;
    else if (ld_we) acc_mem[ld_addr] <= ld_data;
  end

  // Write-order monitor (R5): addresses 0,1,2,... restarting after done.
  always @(negedge clk) begin
    if (rst_n && acc_we) begin
      if (int'(acc_waddr) != wexp) order_err++;
      wexp = done ? 0 : wexp + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference: schoolbook row built from 16-bit half-word partial products.
  function automatic logic [31:0] ref_row(input logic [31:0] y, input int n);
    logic [31:0] c = '0;
    for (int j = 0; j < n; j++) begin
      longint unsigned a  = longint'(op_mem[j]);
      longint unsigned ll = (a & 64'hffff) * (y & 32'hffff);
      longint unsigned lh = (a & 64'hffff) * (y >> 16);
      longint unsigned hl = (a >> 16) * (y & 32'hffff);
      longint unsigned hh = (a >> 16) * (y >> 16);
      longint unsigned s  = ll + (lh << 16) + (hl << 16) + (hh << 32)
                            + longint'(exp_mem[j]) + longint'(c);
      exp_mem[j] = s[31:0];
      c = s[63:32];
    end
    return c;
  endfunction

  task automatic load_acc(input int mode);
    for (int j = 0; j < MAXW; j++) begin
      logic [31:0] v = (mode == 1) ? 32'hffff_ffff : (mode == 2) ? 32'd0 : $urandom();
      exp_mem[j] = v;
      ld_we = 1'b1; ld_addr = AW'(j); ld_data = v;
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic run_row(input logic [31:0] y, input int n, input bit poke);
    logic [31:0] cexp;
    int c0, dc = 0, to = 0, oe0;
    bit seen = 1'b0, we_at = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [31:0] co = '0;
    cexp = ref_row(y, n);
    oe0 = order_err;
    @(negedge clk);
    c0 = cyc; scalar = y; nwords = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && rd_en && rd_addr == '0, "R2", "busy/first read", {busy, rd_en}, 2'b11);
    if (poke) begin
      @(negedge clk);
      scalar = ~y; nwords = CW'(1); start = 1'b1;   // R7: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!seen && to < 500) begin
      if (done) begin
        seen = 1'b1; dc = cyc; we_at = acc_we; wa = acc_waddr; co = carry_out;
      end else begin
        @(negedge clk); to++;
      end
    end
    chk(seen, "R6", "done seen", seen, 1);
    chk(dc - c0 == n + 3, "R6", "done latency", dc - c0, n + 3);
    chk(we_at && int'(wa) == n - 1, "R6", "last write with done", wa, n - 1);
    chk(co == cexp, "R4", "carry_out", co, cexp);
    // R7: start raised during the done cycle is ignored.
    scalar = 32'h1234_5678; nwords = CW'(MAXW); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R9", "idle after done", {busy, done}, 0);
    @(negedge clk);
    chk(!busy && !rd_en, "R7", "start in done cycle ignored", {busy, rd_en}, 0);
    chk(carry_out == cexp, "R6", "carry_out held", carry_out, cexp);
    chk(order_err == oe0, "R5", "write order", order_err - oe0, 0);
    for (int j = 0; j < MAXW; j++) begin
      if (acc_mem[j] !== exp_mem[j])
        chk(1'b0, j < n ? "R4" : "R8", "acc word", acc_mem[j], exp_mem[j]);
    end
    chk(1'b1, "R8", "accumulator image compared", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !acc_we, "R1", "reset outputs",
        {busy, done, rd_en, acc_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_en && !acc_we, "R1", "idle after reset",
        {busy, done, rd_en, acc_we}, 0);

    // Directed: carry chain at its upper bound (R4), full length (R8).
    for (int j = 0; j < MAXW; j++) op_mem[j] = 32'hffff_ffff;
    load_acc(1);
    run_row(32'hffff_ffff, MAXW, 1'b0);
    // Directed: single word, then zero scalar.
    load_acc(0);
    run_row(32'hffff_ffff, 1, 1'b0);
    for (int j = 0; j < MAXW; j++) op_mem[j] = $urandom();
    load_acc(0);
    run_row(32'd0, 7, 1'b0);
    // Operand sizes of 160, 256, 512, 1024 bits (R8), start poked mid-row (R7).
    load_acc(2); run_row($urandom(), 5, 1'b1);
    load_acc(0); run_row($urandom(), 8, 1'b0);
    load_acc(0); run_row($urandom(), 16, 1'b1);
    load_acc(0); run_row($urandom(), 32, 1'b0);
    // Random rows, accumulating without reloading.
    for (int r = 0; r < 12; r++) begin
      int n = 1 + int'($urandom() % MAXW);
      for (int j = 0; j < MAXW; j++) op_mem[j] = $urandom();
      run_row($urandom(), n, r[0]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule